// File: doc/BRIEF.md
# Internal Data Memory Unit

This block holds the 256-byte on-chip data RAM of an 8-bit microcontroller core. It also holds the two control registers that shape how that RAM is seen: the stack pointer and the program status word. The core's execute stage sends it one request at a time. Each request can be:

- a direct or indirect byte access;
- a working-register access;
- a single-bit set, clear or test;
- a one-byte push or pop;
- a two-byte return-address save or restore.

The unit resolves every request to a RAM byte, to one of its own two registers, or to the external special-register port.

The same address means different things depending on how it is used. A direct address in the upper half selects a special register. An indirect address in the upper half selects upper RAM. Register numbers 0 to 7 are moved among four RAM banks by two bits of the status word.

Requests enter on a valid/ready channel, and every accepted request produces exactly one response word on a second valid/ready channel. Back-pressure works as follows:

- While a response waits with `rsp_ready` low, `req_ready` stays low and the response holds still.
- When the response is taken in a cycle, a new request can be accepted in that same cycle.

The external special-register port is a plain strobe interface with a combinational read.

Top module: `iram_unit`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its response appears in `rsp_valid`/`rsp_data` after that edge. `rsp_data` stays unchanged while `rsp_ready` is low. `req_ready` is high exactly when no response is waiting or the waiting one is taken this cycle. Responses to pure writes and to bit set/clear are 0.
- R2: Direct access (op 0 read, op 1 write) to addresses 00h–7Fh and indirect access (op 2 read, op 3 write) to 00h–FFh reach the same RAM bytes. A read returns the byte in `rsp_data[7:0]` with the upper bits 0.
- R3: A direct access to 80h–FFh never touches RAM. Address 81h is the stack pointer and D0h is the status word. Any other address drives the external port: `sfr_wr_en` carries the address and data for a write, and `sfr_rd_en` returns `sfr_rdata` for a read.
- R4: After reset the stack pointer reads 07h and the status word reads 00h.
- R5: Register access (op 4 read, op 5 write, register number in `req_addr[2:0]`) reaches RAM byte {bank, number}. The bank is status-word bits [4:3], so bank 0..3 covers 00h–07h, 08h–0Fh, 10h–17h and 18h–1Fh.
- R6: Status word bit 1 always reads 0, and writes to it have no effect; the other seven bits store what is written.
- R7: Bit ops (op 6 set, op 7 clear, op 8 test) with a bit address of 00h–7Fh act on bit (address mod 8) of RAM byte 20h + address/8. Set and clear leave the other seven bits unchanged. A test returns that bit in `rsp_data[0]`.
- R8: Bit addresses 80h–FFh act on bit (address mod 8) of the direct-space byte at (address AND F8h), by read-modify-write. This includes the status word, so setting bit address D3h switches to register bank 1.
- R9: A push (op 9) first adds 1 to the stack pointer, then writes `req_wdata[7:0]` at the new value, and returns the new pointer. A pop (op 10) returns the byte at the pointer, then subtracts 1. The pointer wraps modulo 256.
- R10: A return-address save (op 11) writes `req_wdata[7:0]` at SP+1 and `req_wdata[15:8]` at SP+2, adds 2 to the pointer and returns the new pointer. A restore (op 12) returns {byte at SP, byte at SP−1} and subtracts 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | 8 | Byte address, bit address or register number |
| req_wdata | input | 16 | Write data; 16 bits only for the return-address save |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Response word |
| sfr_rd_en | output | 1 | External special-register read strobe |
| sfr_wr_en | output | 1 | External special-register write strobe |
| sfr_addr | output | 8 | External special-register address |
| sfr_wdata | output | 8 | External special-register write data |
| sfr_rdata | input | 8 | External special-register read data, same cycle |

## Verification
Every RAM byte is first filled through indirect writes with an address-derived pattern. It is then read back both indirectly and, for the lower half, directly, which shows that the two modes share one store. Direct writes over the whole upper half are checked against the external port and against unchanged upper RAM, which separates the two meanings of an upper address. Each of the 128 RAM bit addresses is set, tested and cleared over bytes holding mixed data, which catches wrong byte or bit selection and clobbered neighbours. All four banks are swept with distinct register values. Stack pushes and pops are run both in the middle of RAM and across the FFh→00h wrap. A stalled response is held for several cycles to check that it stays put and that no new request is taken.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int BYTE_W    = 8;
  localparam int RSP_W     = 2 * BYTE_W;
  localparam int OP_W      = 4;
  localparam int BIT_SEL_W = 3;

  localparam logic [BYTE_W-1:0] SP_LOC    = 8'h81;
  localparam logic [BYTE_W-1:0] PSW_LOC   = 8'hD0;
  localparam logic [BYTE_W-1:0] SP_INIT   = 8'h07;
  localparam logic [BYTE_W-1:0] BIT_BASE  = 8'h20;
  localparam logic [BYTE_W-1:0] PSW_KEEP  = 8'hFD;

  typedef enum logic [OP_W-1:0] {
    OP_DRD  = 4'd0,
    OP_DWR  = 4'd1,
    OP_IRD  = 4'd2,
    OP_IWR  = 4'd3,
    OP_RRD  = 4'd4,
    OP_RWR  = 4'd5,
    OP_BSET = 4'd6,
    OP_BCLR = 4'd7,
    OP_BTST = 4'd8,
    OP_PUSH = 4'd9,
    OP_POP  = 4'd10,
    OP_SAVE = 4'd11,
    OP_REST = 4'd12,
    OP_NONE = 4'd15
  } iram_op_e;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_SP  = 2'd1,
    TGT_PSW = 2'd2,
    TGT_EXT = 2'd3
  } iram_tgt_e;
endpackage

// File: rtl/iram_storage.sv
module iram_storage #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_a,
  input  logic          we_a,
  input  logic [DW-1:0] wd_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] addr_b,
  input  logic          we_b,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= wd_a;
    if (we_b) mem[addr_b] <= wd_b;
  end

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
endmodule

// File: rtl/iram_ctl_regs.sv
module iram_ctl_regs
  import iram_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SP_RST  = SP_INIT,
  parameter logic [BYTE_W-1:0] PSW_MSK = PSW_KEEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_we,
  input  logic [BYTE_W-1:0] sp_d,
  input  logic              psw_we,
  input  logic [BYTE_W-1:0] psw_d,
  output logic [BYTE_W-1:0] sp_q,
  output logic [BYTE_W-1:0] psw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= SP_RST;
      psw_q <= '0;
    end else begin
      if (sp_we)  sp_q  <= sp_d;
      if (psw_we) psw_q <= psw_d & PSW_MSK;
    end
  end
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
(
  input  iram_op_e             op,
  input  logic [BYTE_W-1:0]    addr,
  input  logic [1:0]           bank,
  input  logic [BYTE_W-1:0]    sp,
  output iram_tgt_e            tgt,
  output logic [BYTE_W-1:0]    pri_addr,
  output logic [BYTE_W-1:0]    sec_addr,
  output logic [BIT_SEL_W-1:0] bit_sel
);
  function automatic iram_tgt_e direct_tgt(input logic [BYTE_W-1:0] a);
    if (!a[BYTE_W-1])  return TGT_RAM;
    else if (a == SP_LOC)  return TGT_SP;
    else if (a == PSW_LOC) return TGT_PSW;
    else                   return TGT_EXT;
  endfunction

  logic [BYTE_W-1:0] bit_byte;

  always_comb begin
    if (!addr[BYTE_W-1])
      bit_byte = BIT_BASE + {{(BYTE_W-4){1'b0}}, addr[6:3]};
    else
      bit_byte = {addr[BYTE_W-1:3], 3'b000};
  end

  always_comb begin
    tgt      = TGT_RAM;
    pri_addr = addr;
    sec_addr = addr;
    bit_sel  = addr[BIT_SEL_W-1:0];
    unique case (op)
      OP_DRD, OP_DWR: tgt = direct_tgt(addr);
      OP_IRD, OP_IWR: tgt = TGT_RAM;
      OP_RRD, OP_RWR: pri_addr = {3'b000, bank, addr[2:0]};
      OP_BSET, OP_BCLR, OP_BTST: begin
        pri_addr = bit_byte;
        tgt      = direct_tgt(bit_byte);
      end
      OP_PUSH: pri_addr = sp + 8'd1;
      OP_POP:  pri_addr = sp;
      OP_SAVE: begin
        pri_addr = sp + 8'd1;
        sec_addr = sp + 8'd2;
      end
      OP_REST: begin
        pri_addr = sp;
        sec_addr = sp - 8'd1;
      end
      default: tgt = TGT_RAM;
    endcase
  end
endmodule

// File: rtl/iram_unit.sv
module iram_unit
  import iram_pkg::*;
#(
  parameter logic [7:0] SP_RST = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_op,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  output logic        sfr_rd_en,
  output logic        sfr_wr_en,
  output logic [7:0]  sfr_addr,
  output logic [7:0]  sfr_wdata,
  input  logic [7:0]  sfr_rdata
);
  iram_op_e          op;
  iram_tgt_e         tgt;
  logic              fire;
  logic [BYTE_W-1:0] pri_addr, sec_addr;
  logic [BIT_SEL_W-1:0] bit_sel;
  logic [BYTE_W-1:0] sp_q, psw_q;
  logic [BYTE_W-1:0] ram_a, ram_b;
  logic [BYTE_W-1:0] byte_rd, byte_new, bit_mask;
  logic              is_rd, is_wr;
  logic              ram_we_a, ram_we_b;
  logic [BYTE_W-1:0] ram_wd_a;
  logic              sp_we, psw_we;
  logic [BYTE_W-1:0] sp_d;
  logic [RSP_W-1:0]  rsp_next;

  assign op        = iram_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  iram_addr_map map_i (
    .op       (op),
    .addr     (req_addr),
    .bank     (psw_q[4:3]),
    .sp       (sp_q),
    .tgt      (tgt),
    .pri_addr (pri_addr),
    .sec_addr (sec_addr),
    .bit_sel  (bit_sel)
  );

  iram_storage #(.AW(BYTE_W), .DW(BYTE_W)) ram_i (
    .clk    (clk),
    .addr_a (pri_addr),
    .we_a   (ram_we_a),
    .wd_a   (ram_wd_a),
    .rd_a   (ram_a),
    .addr_b (sec_addr),
    .we_b   (ram_we_b),
    .wd_b   (req_wdata[RSP_W-1:BYTE_W]),
    .rd_b   (ram_b)
  );

  iram_ctl_regs #(.SP_RST(SP_RST)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sp_we  (sp_we),
    .sp_d   (sp_d),
    .psw_we (psw_we),
    .psw_d  (byte_new),
    .sp_q   (sp_q),
    .psw_q  (psw_q)
  );

  // Classify the request: byte-level reads and writes of the resolved target.
  always_comb begin
    is_rd = 1'b0;
    is_wr = 1'b0;
    unique case (op)
      OP_DRD, OP_IRD, OP_RRD, OP_BTST, OP_POP: is_rd = 1'b1;
      OP_DWR, OP_IWR, OP_RWR, OP_PUSH:         is_wr = 1'b1;
      OP_BSET, OP_BCLR: begin
        is_rd = 1'b1;
        is_wr = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (tgt)
      TGT_RAM: byte_rd = ram_a;
      TGT_SP:  byte_rd = sp_q;
      TGT_PSW: byte_rd = psw_q;
      default: byte_rd = sfr_rdata;
    endcase
  end

  assign bit_mask = BYTE_W'(1) << bit_sel;

  always_comb begin
    unique case (op)
      OP_BSET: byte_new = byte_rd | bit_mask;
      OP_BCLR: byte_new = byte_rd & ~bit_mask;
      default: byte_new = req_wdata[BYTE_W-1:0];
    endcase
  end

  assign ram_we_a = fire && ((is_wr && tgt == TGT_RAM) || op == OP_SAVE);
  assign ram_we_b = fire && op == OP_SAVE;
  assign ram_wd_a = (op == OP_SAVE) ? req_wdata[BYTE_W-1:0] : byte_new;
  assign psw_we   = fire && is_wr && tgt == TGT_PSW;

  assign sfr_rd_en = fire && is_rd && tgt == TGT_EXT;
  assign sfr_wr_en = fire && is_wr && tgt == TGT_EXT;
  assign sfr_addr  = pri_addr;
  assign sfr_wdata = byte_new;

  always_comb begin
    sp_we = fire;
    unique case (op)
      OP_PUSH: sp_d = sp_q + 8'd1;
      OP_POP:  sp_d = sp_q - 8'd1;
      OP_SAVE: sp_d = sp_q + 8'd2;
      OP_REST: sp_d = sp_q - 8'd2;
      default: begin
        sp_d  = byte_new;
        sp_we = fire && is_wr && tgt == TGT_SP;
      end
    endcase
  end

  always_comb begin
    rsp_next = '0;
    unique case (op)
      OP_DRD, OP_IRD, OP_RRD, OP_POP: rsp_next = {{BYTE_W{1'b0}}, byte_rd};
      OP_BTST:         rsp_next = {{(RSP_W-1){1'b0}}, byte_rd[bit_sel]};
      OP_PUSH, OP_SAVE: rsp_next = {{BYTE_W{1'b0}}, sp_d};
      OP_REST:         rsp_next = {ram_a, ram_b};
      default:         rsp_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rsp_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iram_unit_chk.sv
module iram_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_op,
  input logic [7:0]  req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        sfr_rd_en,
  input logic        sfr_wr_en,
  input logic [7:0]  sfr_addr,
  input logic [7:0]  sp_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R3
  sfr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_en || sfr_wr_en) |-> sfr_addr[7] && sfr_addr != 8'h81 && sfr_addr != 8'hD0);

  // R6
  psw_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 4'd0 && req_addr == 8'hD0 |=> rsp_data[1] == 1'b0);

  // R9
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 4'd9 |=> sp_q == $past(sp_q) + 8'd1);

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 4'd10 |=> sp_q == $past(sp_q) - 8'd1);

  // R10
  save_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 4'd11 |=> sp_q == $past(sp_q) + 8'd2);

  // R10
  rest_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 4'd12 |=> sp_q == $past(sp_q) - 8'd2);
endmodule

bind iram_unit iram_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .sfr_rd_en (sfr_rd_en),
  .sfr_wr_en (sfr_wr_en),
  .sfr_addr  (sfr_addr),
  .sp_q      (sp_q)
);

// File: tb/iram_unit_tb_top.sv
module iram_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = 4'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        sfr_rd_en, sfr_wr_en;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [256];
  logic [7:0] ext_mem [256];

  always #10 clk = ~clk;

  iram_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sfr_rd_en(sfr_rd_en), .sfr_wr_en(sfr_wr_en),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  assign sfr_rdata = ext_mem[sfr_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ext_mem[i] <= 8'(i) ^ 8'h5A;
    end else if (sfr_wr_en) begin
      ext_mem[sfr_addr] <= sfr_wdata;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] op, input logic [7:0] a,
                      input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_valid ? rsp_data : 16'hDEAD;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 idle after reset
    check("R1 rsp_valid idle", {15'd0, rsp_valid}, 16'd0);
    check("R1 req_ready idle", {15'd0, req_ready}, 16'd1);
    // R4
    xfer(4'd0, 8'h81, 16'd0, r); check("R4 sp reset", r, 16'h0007);
    xfer(4'd0, 8'hD0, 16'd0, r); check("R4 psw reset", r, 16'h0000);

    // R2 fill via indirect, read back both ways
    for (int a = 0; a < 256; a++) begin
      model[a] = pat(a);
      xfer(4'd3, 8'(a), {8'd0, model[a]}, r);
      check("R2 write rsp", r, 16'd0);
    end
    for (int a = 0; a < 256; a++) begin
      xfer(4'd2, 8'(a), 16'd0, r); check("R2 indirect read", r, {8'd0, model[a]});
    end
    for (int a = 0; a < 128; a++) begin
      xfer(4'd0, 8'(a), 16'd0, r); check("R2 direct read", r, {8'd0, model[a]});
    end

    // R3 direct upper range goes to external port
    for (int a = 128; a < 256; a++) begin
      if (a != 8'h81 && a != 8'hD0) begin
        xfer(4'd1, 8'(a), {8'd0, ~8'(a)}, r);
        check("R3 ext written", {8'd0, ext_mem[a]}, {8'd0, ~8'(a)});
        xfer(4'd0, 8'(a), 16'd0, r);
        check("R3 ext read", r, {8'd0, ~8'(a)});
        xfer(4'd2, 8'(a), 16'd0, r);
        check("R3 upper ram untouched", r, {8'd0, model[a]});
      end
    end

    // R5 banks
    for (int b = 0; b < 4; b++) begin
      xfer(4'd1, 8'hD0, {8'd0, 8'(b << 3)}, r);
      for (int n = 0; n < 8; n++) begin
        model[b * 8 + n] = 8'(8'h40 + b * 16 + n);
        xfer(4'd5, 8'(n), {8'd0, model[b * 8 + n]}, r);
        xfer(4'd4, 8'(n), 16'd0, r);
        check("R5 register read", r, {8'd0, model[b * 8 + n]});
      end
    end
    for (int a = 0; a < 32; a++) begin
      xfer(4'd2, 8'(a), 16'd0, r); check("R5 bank placement", r, {8'd0, model[a]});
    end

    // R6
    xfer(4'd1, 8'hD0, 16'h00FF, r);
    xfer(4'd0, 8'hD0, 16'd0, r); check("R6 psw bit1 masked", r, 16'h00FD);
    xfer(4'd1, 8'hD0, 16'h0000, r);

    // R7 RAM bit space
    for (int b = 0; b < 128; b++) begin
      int byt;
      byt = 32 + b / 8;
      model[byt] = model[byt] | 8'(1 << (b % 8));
      xfer(4'd6, 8'(b), 16'd0, r);
      xfer(4'd0, 8'(byt), 16'd0, r); check("R7 set byte", r, {8'd0, model[byt]});
      xfer(4'd8, 8'(b), 16'd0, r); check("R7 test one", r, 16'd1);
      model[byt] = model[byt] & ~8'(1 << (b % 8));
      xfer(4'd7, 8'(b), 16'd0, r);
      xfer(4'd2, 8'(byt), 16'd0, r); check("R7 clear byte", r, {8'd0, model[byt]});
      xfer(4'd8, 8'(b), 16'd0, r); check("R7 test zero", r, 16'd0);
    end

    // R8 special-register bit space
    xfer(4'd6, 8'hD3, 16'd0, r);
    xfer(4'd0, 8'hD0, 16'd0, r); check("R8 psw bit set", r, 16'h0008);
    xfer(4'd4, 8'd2, 16'd0, r); check("R8 bank switch", r, {8'd0, model[8'h0A]});
    xfer(4'd6, 8'hD1, 16'd0, r);
    xfer(4'd0, 8'hD0, 16'd0, r); check("R6 bit op on bit1", r, 16'h0008);
    xfer(4'd7, 8'hD3, 16'd0, r);
    xfer(4'd0, 8'hD0, 16'd0, r); check("R8 psw bit clear", r, 16'h0000);
    e = ext_mem[8'h90] | 8'h10;
    xfer(4'd6, 8'h94, 16'd0, r);
    check("R8 ext bit set", {8'd0, ext_mem[8'h90]}, {8'd0, e});
    xfer(4'd8, 8'h94, 16'd0, r); check("R8 ext bit test", r, 16'd1);
    e = e & 8'hFE;
    xfer(4'd7, 8'h90, 16'd0, r);
    check("R8 ext bit clear", {8'd0, ext_mem[8'h90]}, {8'd0, e});

    // R9 push and pop
    xfer(4'd1, 8'h81, 16'h0040, r);
    xfer(4'd9, 8'd0, 16'h00A1, r); check("R9 push sp", r, 16'h0041);
    xfer(4'd9, 8'd0, 16'h00B2, r); check("R9 push sp2", r, 16'h0042);
    xfer(4'd2, 8'h41, 16'd0, r); check("R9 pushed byte", r, 16'h00A1);
    xfer(4'd10, 8'd0, 16'd0, r); check("R9 pop last", r, 16'h00B2);
    xfer(4'd10, 8'd0, 16'd0, r); check("R9 pop first", r, 16'h00A1);
    xfer(4'd0, 8'h81, 16'd0, r); check("R9 sp restored", r, 16'h0040);
    xfer(4'd1, 8'h81, 16'h00FF, r);
    xfer(4'd9, 8'd0, 16'h0077, r); check("R9 push wrap", r, 16'h0000);
    xfer(4'd2, 8'h00, 16'd0, r); check("R9 wrap byte", r, 16'h0077);
    xfer(4'd10, 8'd0, 16'd0, r); check("R9 pop wrap", r, 16'h0077);
    xfer(4'd0, 8'h81, 16'd0, r); check("R9 sp unwrap", r, 16'h00FF);

    // R10 return address
    xfer(4'd1, 8'h81, 16'h0060, r);
    xfer(4'd11, 8'd0, 16'h1234, r); check("R10 save sp", r, 16'h0062);
    xfer(4'd2, 8'h61, 16'd0, r); check("R10 low first", r, 16'h0034);
    xfer(4'd2, 8'h62, 16'd0, r); check("R10 high second", r, 16'h0012);
    xfer(4'd12, 8'd0, 16'd0, r); check("R10 restore", r, 16'h1234);
    xfer(4'd0, 8'h81, 16'd0, r); check("R10 sp back", r, 16'h0060);

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 4'd0; req_addr = 8'h81;
    @(posedge clk);
    @(negedge clk);
    req_op = 4'd2; req_addr = 8'h61;
    for (int k = 0; k < 3; k++) begin
      check("R1 stall valid", {15'd0, rsp_valid}, 16'd1);
      check("R1 stall data", rsp_data, 16'h0060);
      check("R1 stall ready", {15'd0, req_ready}, 16'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next response", rsp_data, 16'h0034);
    @(negedge clk);
    check("R1 drained", {15'd0, rsp_valid}, 16'd0);

    finish_run();
  end
endmodule